// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM that holds 262,144 bytes behind an 18-bit address and an 8-bit data path. The host hands over one request at a time on a valid/ready channel, giving an address, a write flag and write data. The controller turns each request into a strobe sequence that meets the RAM's minimum timing. Reads return their byte on a one-cycle response pulse.

The RAM is selected only when its active-low enable is low and its active-high enable is high. A read drives output-enable low with write-enable high. A write drives write-enable low with output-enable high. Every timing limit is a parameter in nanoseconds. Each one is converted to a clock count by rounding up, with a floor of one cycle, against a clock-period parameter. Between accesses the controller parks the RAM in standby. It drives the data bus only while a write is in progress. A write that follows a read waits until the RAM has had time to release the bus.

Back-pressure rule: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The host must hold its valid and payload steady until that edge. `req_ready` stays low from the accepting edge until the access has fully ended. The response channel has no ready: the host must accept `rsp_valid` whenever it is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is high, the RAM is in standby: `sram_sel_n`=1, `sram_sel`=0, `sram_oe_n`=1, `sram_we_n`=1 and `sram_dq_oe`=0.
- R2: A read keeps the RAM selected, with `sram_oe_n`=0, `sram_we_n`=1 and `sram_dq_oe`=0, for exactly RD cycles. RD is the largest of the read-cycle, address-access and output-enable access times, each rounded up to whole clock periods (18 at 4 ns).
- R3: The read byte is sampled on the clock edge that ends the read window. It is presented on `rsp_rdata` while `rsp_valid` is high, and that pulse lasts exactly one cycle.
- R4: A write holds `sram_we_n`=0 for exactly WP cycles, with the RAM selected, `sram_oe_n`=1, and the request address and data driven. WP is the largest of the write-pulse, data-setup and address-to-end-of-write times, rounded up (15 at 4 ns).
- R5: After `sram_we_n` rises, the RAM stays selected and the address and data stay driven and unchanged for REC cycles. REC is the rounded write-cycle time minus WP, with a floor of one (3 at 4 ns).
- R6: `sram_dq_oe` is high only while the RAM is selected and `sram_oe_n` is high.
- R7: After a read, `sram_dq_oe` does not rise until at least TA cycles after `sram_oe_n` went high. TA is the bus-release time rounded up (7 at 4 ns).
- R8: `req_ready` is low in every cycle where the RAM is selected. A response pulse coincides with `req_ready` returning high. Each accepted request produces exactly one access.
- R9: A read returns the last byte written to the same address. Addresses reach the RAM pins unaltered across the full range 0x00000 to 0x3FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 8 | Read data |
| sram_addr | output | 18 | RAM address pins |
| sram_sel_n | output | 1 | RAM enable, active low |
| sram_sel | output | 1 | RAM enable, active high |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | 8 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | 8 | Data received from the RAM pads |

## Verification
The bench runs isolated writes and reads, writes to both address extremes, and a run of data patterns (alternating bits, all ones, all zeros). Stuck or swapped data bits therefore show up on readback. A read followed at once by a write exercises the bus-release wait. The same pair with a long idle gap shows that no extra wait is added when the release time has already passed. Back-to-back reads, and an overwrite followed by a readback, separate correct storage ordering from stale data. A RAM model that returns garbage until the read window has lasted its full length exposes any read strobe that is too short.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WREC   = 3'd4
  } sram_st_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // Round a nanosecond figure up to whole clocks, never below one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t decode_strobes(input sram_st_e st);
    strobe_t s;
    s = STROBE_IDLE;
    case (st)
      ST_READ: begin
        s.sel_n = 1'b0; s.sel = 1'b1; s.oe_n = 1'b0;
      end
      ST_WPULSE: begin
        s.sel_n = 1'b0; s.sel = 1'b1; s.we_n = 1'b0; s.dq_oe = 1'b1;
      end
      ST_WREC: begin
        s.sel_n = 1'b0; s.sel = 1'b1; s.dq_oe = 1'b1;
      end
      default: s = STROBE_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned WP_CYC  = 6,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned TA_CYC  = 3,
  parameter int unsigned CNT_W   = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_write,
  output logic     req_ready,
  output logic     accept,
  output logic     rd_done,
  output sram_st_e state_d
);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD  = CNT_W'(TA_CYC);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  sram_st_e         state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rel_q, rel_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_done   = (state_q == ST_READ) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!req_write) begin
            state_d = ST_READ;
            cnt_d   = RD_LAST;
          end else if (rel_q > ONE) begin
            state_d = ST_TURN;
          end else begin
            state_d = ST_WPULSE;
            cnt_d   = WP_LAST;
          end
        end
      end
      ST_READ: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - ONE;
      end
      ST_TURN: begin
        if (rel_q <= ONE) begin
          state_d = ST_WPULSE;
          cnt_d   = WP_LAST;
        end
      end
      ST_WPULSE: begin
        if (cnt_q == '0) begin
          state_d = ST_WREC;
          cnt_d   = REC_LAST;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_WREC: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - ONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Release timer: loaded as a read ends, counts down to zero.
  always_comb begin
    if (rd_done)           rel_d = TA_LOAD;
    else if (rel_q != '0)  rel_d = rel_q - ONE;
    else                   rel_d = rel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rel_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rel_q   <= rel_d;
    end
  end

  // R8: once accepted, the controller leaves idle on the next edge
  p_accept_leaves_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TA_CYC = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_st_e          state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_sel_n,
  output logic              sram_sel,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);

  localparam logic [CNT_W-1:0] TA_SAT = CNT_W'(TA_CYC);

  strobe_t strobe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // Strobes come straight from flops so no decode glitch reaches the pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= STROBE_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= decode_strobes(state_d);
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_wdata;
      end
    end
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = data_q;
  assign sram_sel_n  = strobe_q.sel_n;
  assign sram_sel    = strobe_q.sel;
  assign sram_oe_n   = strobe_q.oe_n;
  assign sram_we_n   = strobe_q.we_n;
  assign sram_dq_oe  = strobe_q.dq_oe;

  // Checker-only counter: cycles since output enable last went high.
  logic [CNT_W-1:0] oe_gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               oe_gap_q <= TA_SAT;
    else if (!strobe_q.oe_n)  oe_gap_q <= '0;
    else if (oe_gap_q < TA_SAT) oe_gap_q <= oe_gap_q + CNT_W'(1);
  end

  p_dq_only_writing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_sel_n && sram_sel));

  p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> ($stable(sram_dq_out) && $stable(sram_addr)));

  p_bus_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_gap_q >= TA_SAT));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= dq_in;
    end
  end

  p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_OE_NS = 35,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_WP_NS = 50,
  parameter int unsigned T_AW_NS = 60,
  parameter int unsigned T_DW_NS = 30,
  parameter int unsigned T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_sel_n,
  output logic              sram_sel,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned RD_CYC = max2(max2(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                        ns2cyc(T_OE_NS, CLK_NS));
  localparam int unsigned WP_CYC = max2(max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)),
                                        ns2cyc(T_AW_NS, CLK_NS));
  localparam int unsigned WC_CYC = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned REC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned TA_CYC = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(REC_CYC, TA_CYC));
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 2);

  sram_st_e state_d;
  logic     accept;
  logic     rd_done;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .rd_done  (rd_done),
    .state_d  (state_d)
  );

  sram_pin_drv #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .TA_CYC(TA_CYC),
    .CNT_W (CNT_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_d    (state_d),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .sram_addr  (sram_addr),
    .sram_sel_n (sram_sel_n),
    .sram_sel   (sram_sel),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_done  (rd_done),
    .dq_in    (sram_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_sel_n && !sram_sel && sram_oe_n && sram_we_n && !sram_dq_oe));

  p_selected_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_sel_n && sram_sel) |-> !req_ready);

  p_rsp_with_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && sram_dq_oe && !sram_sel_n && sram_sel));

  p_read_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_dq_oe));

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int CLK_NS = 4;
  localparam int RD_EXP = 18;  // ceil(70/4)
  localparam int WP_EXP = 15;  // ceil(60/4)
  localparam int REC_EXP = 3;  // 18 - 15
  localparam int TA_EXP = 7;   // ceil(25/4)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0] sram_dq_out;
  logic [7:0] sram_dq_in = 8'hEE;

  always #2 clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- RAM model (acts on falling edges) ----------------
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  int rd_age = 0;
  wire sel_on = !sram_sel_n && sram_sel;
  wire rd_on = sel_on && !sram_oe_n && sram_we_n;

  always @(posedge clk) rd_age <= rd_on ? rd_age + 1 : 0;

  always @(negedge clk) begin
    if (sel_on && !sram_we_n) ram[int'(sram_addr)] = sram_dq_out;
    if (rd_on && rd_age >= RD_EXP - 1)
      sram_dq_in = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : 8'h00;
    else
      sram_dq_in = 8'hEE;
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q [$];
  logic [17:0] cur_addr;
  logic [7:0] cur_wdata;

  task automatic access(input bit wr, input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    cur_addr = a; cur_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    // wait for the access to finish
    while (!req_ready) @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  int rd_len = 0, wp_len = 0, rec_len = 0, oe_age = 100;
  bit rd_bad = 0, wp_bad = 0, rec_bad = 0, in_rec = 0, rsp_prev = 0, ready_prev = 1;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R2 read window
      if (!sram_oe_n && sel_on) begin
        rd_len++;
        if (!sram_we_n || sram_dq_oe || req_ready || sram_addr != cur_addr) rd_bad = 1;
      end else if (rd_len != 0) begin
        chk(rd_len == RD_EXP, "R2 read window length", rd_len, RD_EXP);
        chk(!rd_bad, "R2/R8 read strobe levels", rd_bad, 0);
        rd_len = 0; rd_bad = 0;
      end
      // R4 write pulse
      if (sel_on && !sram_we_n) begin
        wp_len++;
        if (!sram_oe_n || !sram_dq_oe || req_ready || sram_dq_out != cur_wdata || sram_addr != cur_addr)
          wp_bad = 1;
      end else if (wp_len != 0) begin
        chk(wp_len == WP_EXP, "R4 write pulse length", wp_len, WP_EXP);
        chk(!wp_bad, "R4/R8 write strobe levels", wp_bad, 0);
        wp_len = 0; wp_bad = 0; in_rec = 1; rec_len = 0; rec_bad = 0;
      end
      // R5 recovery
      if (in_rec) begin
        if (sel_on && sram_we_n) begin
          rec_len++;
          if (!sram_dq_oe || sram_dq_out != cur_wdata || sram_addr != cur_addr) rec_bad = 1;
        end else begin
          chk(rec_len == REC_EXP, "R5 recovery length", rec_len, REC_EXP);
          chk(!rec_bad, "R5 recovery hold", rec_bad, 0);
          in_rec = 0;
        end
      end
      // R6 / R7 bus ownership
      if (!sram_oe_n) oe_age = 0;
      else if (oe_age < 100) oe_age++;
      if (sram_dq_oe && (oe_age < TA_EXP || !sram_oe_n || !sel_on))
        chk(0, "R6/R7 bus contention", oe_age, TA_EXP);
      // R1 standby on return to idle
      if (req_ready && !ready_prev)
        chk(sram_sel_n && !sram_sel && sram_oe_n && sram_we_n && !sram_dq_oe,
            "R1 idle standby", {sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
      ready_prev = req_ready;
      // R3 / R9 responses
      if (rsp_valid) begin
        chk(!rsp_prev, "R3 single-cycle pulse", 1, 0);
        chk(req_ready, "R8 response with ready", req_ready, 1);
        if (exp_q.size() == 0) chk(0, "R8 unexpected response", rsp_rdata, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R3/R9 read data", rsp_rdata, e);
        end
      end
      rsp_prev = rsp_valid;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(sram_sel_n && !sram_sel && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid,
        "R1 reset standby", {sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready, "R8 ready after reset", req_ready, 1);

    access(1, 18'h00000, 8'hA5);
    access(1, 18'h3FFFF, 8'h5A);
    access(1, 18'h12345, 8'hFF);
    access(1, 18'h2AAAA, 8'h00);
    access(0, 18'h00000, 8'h00);   // R9 low corner
    access(0, 18'h3FFFF, 8'h00);   // R9 high corner
    access(0, 18'h12345, 8'h00);
    access(1, 18'h15555, 8'h3C);   // R7 write right after read
    access(0, 18'h2AAAA, 8'h00);
    repeat (12) @(negedge clk);
    access(1, 18'h00001, 8'hC3);   // R7 gap already elapsed
    access(1, 18'h12345, 8'h81);   // overwrite
    access(0, 18'h12345, 8'h00);
    access(0, 18'h15555, 8'h00);
    access(0, 18'h00001, 8'h00);
    access(0, 18'h0BEEF, 8'h00);   // never written
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every read answered", exp_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule